// File: doc/BRIEF.md
# Masked Byte-Register Interrupt Front End

This block collects up to eight interrupt requests into an 8-bit pending register and presents one level-sensitive request line to a host-side aggregator. Hardware sources raise and drop pending bits through two bit-vector strobes, one that sets bits and one that clears them. Software controls the block through a small byte-wide register bus. It can enable sources through a primary mask, read back which sources are pending, and retire one source at a time by writing its bit number to the acknowledge register.

The primary mask is held internally as an enable vector, which is the complement of the byte software writes. It reads back in the written sense. A secondary controller is present only as decode: its mask register holds a byte, and its status register reads zero. It never drives the request line. Several legacy housekeeping offsets (keyboard, DMA command, DMA mask and DMA reset, secondary acknowledge, speaker port) accept writes and discard them. Two DMA mode registers keep the byte last written to them. An access to an unknown offset, or an access of an illegal size, sets a sticky error flag and does not stop the block.

Top module: `irq_front`

## Requirements
- R1: After reset the pending register, both masks, both mode registers, `irq_out` and `acc_err` are zero. The primary mask and the secondary mask each read back as 0xFF.
- R2: A byte write to offset 0x01 (primary mask) stores the complement of the written byte as the enable vector. A 0 in the written byte enables that source. A read of 0x01 returns the byte last written.
- R3: A byte write to offset 0x03 (secondary mask) stores the byte unchanged, and a read of 0x03 returns its complement. Writing it never changes `irq_out`. A read of offset 0x02 (secondary status) always returns zero.
- R4: A byte read of offset 0x00 returns the pending register in bits 7:0 with zeros above. A 64-bit read (`reg_wide`=1) is legal only at 0x00, where it returns the pending register zero-extended to 64 bits.
- R5: In every cycle the pending register becomes ((pending | `src_set`) & ~`src_clr`). A bit that is both set and cleared in the same cycle ends up cleared.
- R6: A byte write to offset 0x00 is an acknowledge. When bit 3 of the written byte is 0, it clears the pending bit numbered by bits 2:0. A value with bit 3 set (numbers 8..15) clears nothing. The acknowledge is applied after the set and clear strobes of the same cycle.
- R7: One clock after any update, `irq_out` is 1 exactly when (pending & enable) is nonzero.
- R8: Byte writes to offset 0x04 and offset 0x05 (mode A and mode B) store the byte, and reads of those offsets return it.
- R9: Byte writes to offsets 0x08..0x0F are accepted without error and change no state. Reads of those offsets return zero.
- R10: A read or write of an offset outside 0x00..0x05 and 0x08..0x0F, a 64-bit write anywhere, or a 64-bit read at any offset other than 0x00 sets `acc_err` on the next clock. The flag stays set until reset. Such an illegal write changes no state, and such an illegal read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = byte access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 64 | Read data, combinational from the current state while `reg_rd` is high |
| src_set | input | 8 | Pending-bit set vector |
| src_clr | input | 8 | Pending-bit clear vector |
| irq_out | output | 1 | Level request to the host aggregator |
| acc_err | output | 1 | Sticky illegal-access flag |

## Verification
A wrong enable or pending bit shows up at `irq_out` one clock after the update that exposes it. It also shows up as a wrong byte on the next read of offset 0x00 or 0x01, so the sweep pairs every pending pattern with a spread of masks and compares both the request line and the readback at each step. A wrong acknowledge decode leaves a stray bit visible in the status read that follows immediately. An error flag that is set in error, or that clears itself, shows on `acc_err` one clock after the access, and it stays visible from then on.

// File: rtl/irq_front.sv
module irq_front (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_wide,
  input  logic [7:0]  reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic [7:0]  src_set,
  input  logic [7:0]  src_clr,
  output logic        irq_out,
  output logic        acc_err
);

  localparam logic [7:0] A_PSTAT = 8'h00;
  localparam logic [7:0] A_PMASK = 8'h01;
  localparam logic [7:0] A_SSTAT = 8'h02;
  localparam logic [7:0] A_SMASK = 8'h03;
  localparam logic [7:0] A_MODEA = 8'h04;
  localparam logic [7:0] A_MODEB = 8'h05;

  logic [7:0] pend, en, smask, mode_a, mode_b;
  logic [7:0] rd_byte, ack_vec, pend_nx, en_nx;
  logic       known, rd_legal, wr_legal, wr_go, bad;

  always_comb begin
    known   = 1'b1;
    rd_byte = 8'h00;
    case (reg_addr)
      A_PSTAT: rd_byte = pend;
      A_PMASK: rd_byte = ~en;
      A_SSTAT: rd_byte = 8'h00;
      A_SMASK: rd_byte = ~smask;
      A_MODEA: rd_byte = mode_a;
      A_MODEB: rd_byte = mode_b;
      8'h08, 8'h09, 8'h0A, 8'h0B,
      8'h0C, 8'h0D, 8'h0E, 8'h0F: rd_byte = 8'h00;
      default: known = 1'b0;
    endcase
  end

  assign rd_legal  = known && (!reg_wide || reg_addr == A_PSTAT);
  assign wr_legal  = known && !reg_wide;
  assign wr_go     = reg_wr && wr_legal;
  assign bad       = (reg_rd && !rd_legal) || (reg_wr && !wr_legal);
  assign reg_rdata = (reg_rd && rd_legal) ? {56'd0, rd_byte} : 64'd0;

  assign ack_vec = (wr_go && reg_addr == A_PSTAT && !reg_wdata[3])
                   ? (8'h01 << reg_wdata[2:0]) : 8'h00;
  assign pend_nx = ((pend | src_set) & ~src_clr) & ~ack_vec;
  assign en_nx   = (wr_go && reg_addr == A_PMASK) ? ~reg_wdata : en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 8'h00;
      en      <= 8'h00;
      smask   <= 8'h00;
      mode_a  <= 8'h00;
      mode_b  <= 8'h00;
      irq_out <= 1'b0;
      acc_err <= 1'b0;
    end else begin
      pend    <= pend_nx;
      en      <= en_nx;
      irq_out <= |(pend_nx & en_nx);
      if (bad) acc_err <= 1'b1;
      if (wr_go && reg_addr == A_SMASK) smask  <= reg_wdata;
      if (wr_go && reg_addr == A_MODEA) mode_a <= reg_wdata;
      if (wr_go && reg_addr == A_MODEB) mode_b <= reg_wdata;
    end
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(pend & en)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wide && reg_addr == A_PSTAT && !reg_wdata[3])
    |=> !pend[$past(reg_wdata[2:0])]); // R6

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && (src_set & ~src_clr) != 8'h00)
    |=> ((pend & $past(src_set & ~src_clr)) == $past(src_set & ~src_clr))); // R5

  AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SMASK && src_set == 8'h00 && src_clr == 8'h00)
    |=> $stable(irq_out)); // R3

endmodule

// File: tb/test_irq_front.sv
module test_irq_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_wide = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [63:0] reg_rdata;
  logic [7:0]  src_set = 8'h00, src_clr = 8'h00;
  logic        irq_out, acc_err;

  int n_chk = 0, n_err = 0;
  logic [7:0] pm = 8'h00, em = 8'h00;
  logic [63:0] v;

  always #4 clk = ~clk;

  irq_front i_irq_front (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wide(reg_wide), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_set(src_set), .src_clr(src_clr),
    .irq_out(irq_out), .acc_err(acc_err));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic w);
    reg_addr = a; reg_wdata = d; reg_wide = w; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w, output logic [63:0] r);
    reg_addr = a; reg_wide = w; reg_rd = 1'b1;
    #1 r = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] s, input logic [7:0] c);
    src_set = s; src_clr = c;
    @(negedge clk);
    src_set = 8'h00; src_clr = 8'h00;
    pm = (pm | s) & ~c;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", irq_out, 1'b0);
    chk("R1 err", acc_err, 1'b0);
    rd(8'h01, 1'b0, v); chk("R1 pmask", v, 64'hFF);
    rd(8'h03, 1'b0, v); chk("R1 smask", v, 64'hFF);
    rd(8'h00, 1'b0, v); chk("R1 pend", v, 64'h0);
    rd(8'h04, 1'b0, v); chk("R1 modeA", v, 64'h0);
    rd(8'h05, 1'b0, v); chk("R1 modeB", v, 64'h0);

    for (int p = 0; p < 256; p++) begin
      strobe(p[7:0], ~p[7:0]);
      for (int k = 0; k < 16; k++) begin
        logic [7:0] m;
        m = k[7:0] * 8'd17 ^ p[7:0];
        wr(8'h01, m, 1'b0); em = ~m;
        chk("R7 irq sweep", irq_out, |(pm & em));
        rd(8'h01, 1'b0, v); chk("R2 mask readback", v, {56'd0, m});
        rd(8'h00, 1'b0, v); chk("R4 status", v, {56'd0, pm});
      end
    end

    wr(8'h01, 8'h00, 1'b0); em = 8'hFF;
    strobe(8'h00, 8'hFF);
    strobe(8'h0F, 8'h00);
    strobe(8'hF0, 8'h3C);
    rd(8'h00, 1'b0, v); chk("R5 set/clear order", v, 64'hC3);
    chk("R7 irq after strobes", irq_out, 1'b1);

    for (int a = 0; a < 16; a++) begin
      strobe(8'hFF, 8'h00);
      wr(8'h00, 8'hA0 | a[7:0], 1'b0);
      if (a < 8) pm = pm & ~(8'h01 << a);
      rd(8'h00, 1'b0, v); chk("R6 ack sweep", v, {56'd0, pm});
    end

    strobe(8'h00, 8'hFF);
    src_set = 8'h05;
    wr(8'h00, 8'h02, 1'b0);
    src_set = 8'h00; pm = 8'h01;
    rd(8'h00, 1'b0, v); chk("R6 set then ack", v, 64'h01);

    strobe(8'h08, 8'hF7);
    wr(8'h01, 8'hF7, 1'b0); em = 8'h08;
    chk("R7 irq single source", irq_out, 1'b1);
    wr(8'h00, 8'h03, 1'b0); pm = 8'h00;
    chk("R6 R7 irq drops on ack", irq_out, 1'b0);

    strobe(8'h81, 8'h00);
    wr(8'h01, 8'hFF, 1'b0); em = 8'h00;
    wr(8'h03, 8'h5A, 1'b0);
    chk("R3 smask no irq", irq_out, 1'b0);
    rd(8'h03, 1'b0, v); chk("R3 smask readback", v, 64'hA5);
    rd(8'h02, 1'b0, v); chk("R3 sstat zero", v, 64'h0);
    rd(8'h00, 1'b1, v); chk("R4 wide status", v, 64'h81);

    wr(8'h04, 8'h3C, 1'b0);
    wr(8'h05, 8'hC3, 1'b0);
    rd(8'h04, 1'b0, v); chk("R8 modeA", v, 64'h3C);
    rd(8'h05, 1'b0, v); chk("R8 modeB", v, 64'hC3);

    for (int a = 8; a < 16; a++) begin
      wr(a[7:0], 8'hFF, 1'b0);
      rd(a[7:0], 1'b0, v); chk("R9 ignored read", v, 64'h0);
    end
    rd(8'h00, 1'b0, v); chk("R9 pend intact", v, 64'h81);
    rd(8'h01, 1'b0, v); chk("R9 mask intact", v, 64'hFF);
    rd(8'h04, 1'b0, v); chk("R9 mode intact", v, 64'h3C);
    chk("R9 no err", acc_err, 1'b0);

    rd(8'h01, 1'b1, v); chk("R10 wide read zero", v, 64'h0);
    chk("R10 err set", acc_err, 1'b1);
    wr(8'h01, 8'h00, 1'b1);
    rd(8'h01, 1'b0, v); chk("R10 wide write ignored", v, 64'hFF);
    rd(8'h06, 1'b0, v); chk("R10 undecoded read", v, 64'h0);
    wr(8'h40, 8'h12, 1'b0);
    rd(8'h00, 1'b0, v); chk("R10 undecoded write", v, 64'h81);
    repeat (4) @(negedge clk);
    chk("R10 sticky", acc_err, 1'b1);
    chk("R7 irq final", irq_out, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule